// File: doc/BRIEF.md
# Issue Queue with Wakeup and Oldest-First Select

This block sits between an in-order decode stage and the issue stage of a single-issue core. Decoded instructions enter in program order at the tail of a circular buffer. Each instruction carries an opcode, an immediate, a destination register specifier and two source specifiers. Every specifier has a valid flag. Each source also has a waiting flag, which comes from an external lookup of registers that still have a result outstanding. Instructions leave the queue out of order, one per cycle, as soon as their operands are available and their functional unit can take them.

A completing producer broadcasts its destination register on the wakeup port. Every stored source that names that register stops waiting. The broadcast also counts in the same cycle it arrives, so a dependent instruction can be picked in the cycle its producer announces itself (back-to-back issue). Age is measured from the head pointer. A slot freed in the middle of the occupied span is not reused until the head walks past it.

Top module: `iq_issue_queue`

## Requirements
- R1: During and directly after synchronous reset the queue is empty: `out_valid` is 0 and `full` is 0.
- R2: An instruction accepted at a clock edge can appear on the issue outputs no earlier than the second following edge. The issued opcode, immediate, destination and source fields equal the values that were allocated.
- R3: A stored instruction is eligible only when each of its sources is either marked invalid or no longer waiting. A wakeup naming a different register leaves it waiting.
- R4: A wakeup on `wake_reg` clears the waiting flag of every stored source with that specifier. The wakeup also counts as cleared in the cycle it is presented, so the dependent instruction can issue at that same edge.
- R5: If a source is accepted with its waiting flag set while a wakeup for the same register is presented in that cycle, it is stored as not waiting.
- R6: Opcode value 2 uses the multiplier and every other opcode value uses the ALU. An instruction is not issued while `mul_busy` (multiplier) or `alu_busy` (ALU) for its unit is high.
- R7: Among the eligible instructions, the one nearest the head (oldest) issues, even when an older instruction that is not eligible stays behind.
- R8: `full` is high when the occupied span from the head reaches DEPTH slots (DEPTH is 4 by default). An allocation presented while `full` is high is dropped.
- R9: A slot freed behind the head does not clear `full`. Only when the head instruction leaves does the head advance past all freed slots, which releases them.
- R10: At most one instruction issues per edge, and `out_valid` is 0 after an edge at which nothing was eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Allocate a new instruction this cycle |
| in_op | input | OP_W | Opcode (2 = multiplier) |
| in_imm | input | IMM_W | Immediate |
| in_dst_vld | input | 1 | Destination specifier is meaningful |
| in_dst | input | REG_W | Destination register |
| in_a_vld | input | 1 | First source is meaningful |
| in_a | input | REG_W | First source register |
| in_a_wait | input | 1 | First source result still outstanding |
| in_b_vld | input | 1 | Second source is meaningful |
| in_b | input | REG_W | Second source register |
| in_b_wait | input | 1 | Second source result still outstanding |
| wake_valid | input | 1 | Wakeup broadcast present |
| wake_reg | input | REG_W | Register being produced |
| alu_busy | input | 1 | ALU cannot accept an instruction |
| mul_busy | input | 1 | Multiplier cannot accept an instruction |
| full | output | 1 | No allocation accepted next edge |
| out_valid | output | 1 | Issue outputs carry an instruction |
| out_op | output | OP_W | Issued opcode |
| out_imm | output | IMM_W | Issued immediate |
| out_dst_vld | output | 1 | Issued destination valid |
| out_dst | output | REG_W | Issued destination |
| out_a_vld | output | 1 | Issued first source valid |
| out_a | output | REG_W | Issued first source |
| out_b_vld | output | 1 | Issued second source valid |
| out_b | output | REG_W | Issued second source |

## Verification
Some properties are checked in every cycle: at most one slot is picked, the pick is an occupied slot whose unit is not busy, a wakeup or allocation-time wakeup leaves the matching source not waiting, and an allocation against `full` never raises occupancy. Other behaviour only shows in the bench's scenarios against its reference model: oldest-first ordering around stalled older entries, the exact issue latency, payload integrity, and the rule that freed middle slots are released only when the head leaves.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_MUL = 1'b1
  } unit_e;

  localparam int MUL_OPCODE = 2;

  function automatic unit_e unit_of(input int unsigned opcode);
    return (opcode == MUL_OPCODE) ? UNIT_MUL : UNIT_ALU;
  endfunction

endpackage

// File: rtl/iq_payload_ram.sv
module iq_payload_ram #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/iq_slot_state.sv
module iq_slot_state
  import iq_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             occupied,
  input  unit_e            unit_in,
  input  logic             a_vld_in,
  input  logic [REG_W-1:0] a_in,
  input  logic             a_wait_in,
  input  logic             b_vld_in,
  input  logic [REG_W-1:0] b_in,
  input  logic             b_wait_in,
  input  logic             wake_valid,
  input  logic [REG_W-1:0] wake_reg,
  input  logic             alu_busy,
  input  logic             mul_busy,
  output logic             ready,
  output unit_e            unit_q
);

  logic             a_vld_q, b_vld_q;
  logic [REG_W-1:0] a_q, b_q;
  logic             a_wait_q, b_wait_q;
  logic             a_hit, b_hit, a_live, b_live, unit_stall;
  logic             a_in_hit, b_in_hit;

  always_comb begin
    a_hit      = wake_valid && (wake_reg == a_q);
    b_hit      = wake_valid && (wake_reg == b_q);
    a_in_hit   = wake_valid && (wake_reg == a_in);
    b_in_hit   = wake_valid && (wake_reg == b_in);
    a_live     = a_vld_q && a_wait_q && !a_hit;
    b_live     = b_vld_q && b_wait_q && !b_hit;
    unit_stall = (unit_q == UNIT_MUL) ? mul_busy : alu_busy;
    ready      = occupied && !a_live && !b_live && !unit_stall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld_q  <= 1'b0;
      b_vld_q  <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      a_wait_q <= 1'b0;
      b_wait_q <= 1'b0;
      unit_q   <= UNIT_ALU;
    end else if (we) begin
      a_vld_q  <= a_vld_in;
      b_vld_q  <= b_vld_in;
      a_q      <= a_in;
      b_q      <= b_in;
      a_wait_q <= a_vld_in && a_wait_in && !a_in_hit;
      b_wait_q <= b_vld_in && b_wait_in && !b_in_hit;
      unit_q   <= unit_in;
    end else begin
      if (a_hit) a_wait_q <= 1'b0;
      if (b_hit) b_wait_q <= 1'b0;
    end
  end

  // R4: a broadcast for a stored source leaves it no longer waiting
  p_wake_clears_a_r4: assert property (@(posedge clk) disable iff (rst)
    (!we && wake_valid && a_vld_q && wake_reg == a_q) |=> !a_wait_q);
  p_wake_clears_b_r4: assert property (@(posedge clk) disable iff (rst)
    (!we && wake_valid && b_vld_q && wake_reg == b_q) |=> !b_wait_q);

  // R5: a broadcast coinciding with allocation is not lost
  p_alloc_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (we && wake_valid && wake_reg == a_in) |=> !a_wait_q);

endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] ready,
  input  logic [PTR_W-1:0] head,
  output logic             found,
  output logic [PTR_W-1:0] idx,
  output logic [DEPTH-1:0] onehot
);

  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] pos;
      pos = PTR_W'((int'(head) + k) % DEPTH);
      if (!found && ready[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
    if (found) onehot[idx] = 1'b1;
  end

endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int REG_W = 5,
  parameter int OP_W  = 2,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_dst_vld,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_a_vld,
  input  logic [REG_W-1:0] in_a,
  input  logic             in_a_wait,
  input  logic             in_b_vld,
  input  logic [REG_W-1:0] in_b,
  input  logic             in_b_wait,
  input  logic             wake_valid,
  input  logic [REG_W-1:0] wake_reg,
  input  logic             alu_busy,
  input  logic             mul_busy,
  output logic             full,
  output logic             out_valid,
  output logic [OP_W-1:0]  out_op,
  output logic [IMM_W-1:0] out_imm,
  output logic             out_dst_vld,
  output logic [REG_W-1:0] out_dst,
  output logic             out_a_vld,
  output logic [REG_W-1:0] out_a,
  output logic             out_b_vld,
  output logic [REG_W-1:0] out_b
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PAY_W = OP_W + IMM_W + 3 + 3 * REG_W;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] base, input int off);
    return PTR_W'((int'(base) + off) % DEPTH);
  endfunction

  logic [PTR_W-1:0] head_q, head_n, tail;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_after, skip;
  logic [DEPTH-1:0] valid_q, valid_n, ready_vec, sel_oh;
  unit_e            unit_vec [DEPTH];
  logic             alloc_fire, sel_any, full_q, out_valid_q, skip_stop;
  logic [PTR_W-1:0] sel_idx;
  logic [PAY_W-1:0] pay_wr, pay_rd;
  unit_e            in_unit;

  assign alloc_fire = in_valid && !full_q;
  assign tail       = wrap_add(head_q, int'(cnt_q));
  assign in_unit    = unit_of(int'(in_op));
  assign pay_wr     = {in_op, in_imm, in_dst_vld, in_dst, in_a_vld, in_a, in_b_vld, in_b};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    iq_slot_state #(.REG_W(REG_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .we         (alloc_fire && (tail == PTR_W'(i))),
      .occupied   (valid_q[i]),
      .unit_in    (in_unit),
      .a_vld_in   (in_a_vld),
      .a_in       (in_a),
      .a_wait_in  (in_a_wait),
      .b_vld_in   (in_b_vld),
      .b_in       (in_b),
      .b_wait_in  (in_b_wait),
      .wake_valid (wake_valid),
      .wake_reg   (wake_reg),
      .alu_busy   (alu_busy),
      .mul_busy   (mul_busy),
      .ready      (ready_vec[i]),
      .unit_q     (unit_vec[i])
    );
  end

  iq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .ready  (ready_vec),
    .head   (head_q),
    .found  (sel_any),
    .idx    (sel_idx),
    .onehot (sel_oh)
  );

  iq_payload_ram #(.DEPTH(DEPTH), .WIDTH(PAY_W)) u_ram (
    .clk   (clk),
    .we    (alloc_fire),
    .waddr (tail),
    .wdata (pay_wr),
    .re    (sel_any),
    .raddr (sel_idx),
    .rdata (pay_rd)
  );

  // Occupancy and head movement: the head skips freed slots only from its own position.
  always_comb begin
    valid_n = valid_q;
    if (sel_any)    valid_n[sel_idx] = 1'b0;
    if (alloc_fire) valid_n[tail]    = 1'b1;
    cnt_after = cnt_q + CNT_W'(alloc_fire);
    skip      = '0;
    skip_stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!skip_stop && (CNT_W'(k) < cnt_after) && !valid_n[wrap_add(head_q, k)])
        skip = skip + CNT_W'(1);
      else
        skip_stop = 1'b1;
    end
    head_n = wrap_add(head_q, int'(skip));
    cnt_n  = cnt_after - skip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      head_q      <= '0;
      cnt_q       <= '0;
      full_q      <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      valid_q     <= valid_n;
      head_q      <= head_n;
      cnt_q       <= cnt_n;
      full_q      <= (cnt_n == CNT_W'(DEPTH));
      out_valid_q <= sel_any;
    end
  end

  assign full      = full_q;
  assign out_valid = out_valid_q;
  assign {out_op, out_imm, out_dst_vld, out_dst, out_a_vld, out_a, out_b_vld, out_b} = pay_rd;

  // R1: the queue comes out of reset empty
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !full));

  // R10: no more than one slot is picked per cycle
  p_single_pick_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_oh));

  // R7: the picked slot is an occupied one
  p_pick_occupied_r7: assert property (@(posedge clk) disable iff (rst)
    sel_any |-> valid_q[sel_idx]);

  // R6: nothing goes to a busy unit
  p_mul_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_any && unit_vec[sel_idx] == UNIT_MUL) |-> !mul_busy);
  p_alu_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_any && unit_vec[sel_idx] == UNIT_ALU) |-> !alu_busy);

  // R8: an allocation against a full queue never raises occupancy
  p_full_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (full && in_valid) |=> ($countones(valid_q) <= $past($countones(valid_q))));

  // R2: an issue follows a cycle in which something was stored
  p_issue_from_store_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(|valid_q));

endmodule

// File: tb/tb_iq_issue_queue.sv
module tb_iq_issue_queue;

  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4ns clk = ~clk;

  logic       a_v, a_dv, a_sav, a_sap, a_sbv, a_sbp, wk_v, alu_b, mul_b;
  logic [1:0] a_op;
  logic [7:0] a_imm;
  logic [4:0] a_dst, a_sa, a_sb, wk_t;

  logic       full, o_v, o_dv, o_av, o_bv;
  logic [1:0] o_op;
  logic [7:0] o_imm;
  logic [4:0] o_dst, o_a, o_b;

  iq_issue_queue #(.DEPTH(QD), .REG_W(5), .OP_W(2), .IMM_W(8)) dut (
    .clk(clk), .rst(rst),
    .in_valid(a_v), .in_op(a_op), .in_imm(a_imm), .in_dst_vld(a_dv), .in_dst(a_dst),
    .in_a_vld(a_sav), .in_a(a_sa), .in_a_wait(a_sap),
    .in_b_vld(a_sbv), .in_b(a_sb), .in_b_wait(a_sbp),
    .wake_valid(wk_v), .wake_reg(wk_t), .alu_busy(alu_b), .mul_busy(mul_b),
    .full(full), .out_valid(o_v), .out_op(o_op), .out_imm(o_imm),
    .out_dst_vld(o_dv), .out_dst(o_dst), .out_a_vld(o_av), .out_a(o_a),
    .out_b_vld(o_bv), .out_b(o_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model, built from the requirements
  bit mv[QD], mdv[QD], mav[QD], maw[QD], mbv[QD], mbw[QD];
  int mop[QD], mimm[QD], md[QD], ma[QD], mb[QD];
  int mhead, mcnt;
  bit mfull, e_iv, e_dv, e_av, e_bv;
  int e_op, e_imm, e_d, e_a, e_b;

  always @(posedge clk) begin : model
    int sel;
    if (rst) begin
      for (int i = 0; i < QD; i++) mv[i] = 0;
      mhead = 0; mcnt = 0; mfull = 0; e_iv = 0;
    end else begin
      sel = -1;
      for (int k = 0; k < QD; k++) begin
        int idx;
        bit wa, wb, bz;
        idx = (mhead + k) % QD;
        wa = mav[idx] && maw[idx] && !(wk_v && wk_t == ma[idx]);
        wb = mbv[idx] && mbw[idx] && !(wk_v && wk_t == mb[idx]);
        bz = (mop[idx] == 2) ? mul_b : alu_b;
        if (sel < 0 && mv[idx] && !wa && !wb && !bz) sel = idx;
      end
      e_iv = (sel >= 0);
      if (sel >= 0) begin
        e_op = mop[sel]; e_imm = mimm[sel]; e_dv = mdv[sel]; e_d = md[sel];
        e_av = mav[sel]; e_a = ma[sel]; e_bv = mbv[sel]; e_b = mb[sel];
        mv[sel] = 0;
      end
      for (int i = 0; i < QD; i++) begin
        if (wk_v && ma[i] == wk_t) maw[i] = 0;
        if (wk_v && mb[i] == wk_t) mbw[i] = 0;
      end
      if (a_v && !mfull) begin
        int t;
        t = (mhead + mcnt) % QD;
        mv[t] = 1; mop[t] = a_op; mimm[t] = a_imm; mdv[t] = a_dv; md[t] = a_dst;
        mav[t] = a_sav; ma[t] = a_sa; mbv[t] = a_sbv; mb[t] = a_sb;
        maw[t] = a_sav && a_sap && !(wk_v && wk_t == a_sa);
        mbw[t] = a_sbv && a_sbp && !(wk_v && wk_t == a_sb);
        mcnt++;
      end
      while (mcnt > 0 && !mv[mhead]) begin
        mhead = (mhead + 1) % QD;
        mcnt--;
      end
      mfull = (mcnt == QD);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk("R7 R10 out_valid vs model", o_v, e_iv);
    chk("R8 full vs model", full, mfull);
    if (e_iv && o_v) begin
      chk("R2 op", o_op, e_op);
      chk("R2 imm", o_imm, e_imm);
      chk("R2 dst", {o_dv, o_dst}, {e_dv, e_d[4:0]});
      chk("R2 src a", {o_av, o_a}, {e_av, e_a[4:0]});
      chk("R2 src b", {o_bv, o_b}, {e_bv, e_b[4:0]});
    end
  endtask

  task automatic idle();
    a_v = 0; a_op = 0; a_imm = 0; a_dv = 0; a_dst = 0;
    a_sav = 0; a_sa = 0; a_sap = 0; a_sbv = 0; a_sb = 0; a_sbp = 0;
    wk_v = 0; wk_t = 0;
  endtask

  task automatic put(input int op, input int imm, input bit av, input int ta, input bit aw);
    a_v = 1; a_op = op[1:0]; a_imm = imm[7:0]; a_dv = 1; a_dst = 5'(imm + 1);
    a_sav = av; a_sa = ta[4:0]; a_sap = aw; a_sbv = 0; a_sb = 0; a_sbp = 0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    idle(); alu_b = 0; mul_b = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", o_v, 0);
    rst = 0;
    cycle();
    chk("R1 out_valid after reset", o_v, 0);
    chk("R1 full after reset", full, 0);

    // R2: latency and payload
    put(0, 8'h5A, 0, 0, 0);
    cycle();
    chk("R2 not issued at first edge", o_v, 0);
    idle();
    cycle();
    chk("R2 issued at second edge", o_v, 1);
    chk("R2 imm carried", o_imm, 8'h5A);

    // R3 / R4
    put(1, 20, 1, 3, 1);
    cycle(); idle();
    cycle();
    chk("R3 waiting source blocks", o_v, 0);
    wk_v = 1; wk_t = 4;
    cycle();
    chk("R3 other wakeup ignored", o_v, 0);
    wk_t = 3;
    cycle();
    chk("R4 same-cycle wakeup issues", o_v, 1);
    chk("R4 issued imm", o_imm, 20);
    idle();

    // R5
    put(0, 30, 1, 6, 1); wk_v = 1; wk_t = 6;
    cycle(); idle();
    cycle();
    chk("R5 wakeup at allocation", o_v, 1);
    chk("R5 issued imm", o_imm, 30);

    // R6 / R7
    mul_b = 1;
    put(2, 40, 0, 0, 0);
    cycle();
    put(0, 41, 0, 0, 0);
    cycle();
    chk("R6 busy multiplier holds mul", o_v, 0);
    idle();
    cycle();
    chk("R7 younger ALU op passes", o_v, 1);
    chk("R7 younger imm", o_imm, 41);
    mul_b = 0;
    cycle();
    chk("R6 mul issues once free", o_v, 1);
    chk("R6 mul imm", o_imm, 40);
    cycle();
    chk("R10 idle when empty", o_v, 0);

    // R8 / R9
    for (int i = 0; i < QD; i++) begin
      put(1, 10 + i, 1, 11 + i, 1);
      cycle();
    end
    chk("R8 full after DEPTH allocs", full, 1);
    put(0, 99, 0, 0, 0); wk_v = 1; wk_t = 12;
    cycle();
    chk("R7 second entry issues first", o_imm, 11);
    chk("R9 full kept with freed middle slot", full, 1);
    idle();
    cycle();
    chk("R9 still full", full, 1);
    wk_v = 1; wk_t = 11;
    cycle();
    chk("R9 head issue", o_imm, 10);
    chk("R9 full released past hole", full, 0);
    wk_t = 13; cycle();
    wk_t = 14; cycle();
    idle();
    cycle();
    chk("R8 dropped alloc never issues", o_v, 0);

    // Sweep
    lf = 32'h1234_5678;
    for (int n = 0; n < 6000; n++) begin
      int unsigned r, s;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; r = lf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; s = lf;
      a_v = r[0] | r[1]; a_op = r[3:2]; a_imm = r[11:4]; a_dv = r[12]; a_dst = r[17:13];
      a_sav = r[18]; a_sa = {2'b0, r[21:19]}; a_sap = r[22];
      a_sbv = r[23]; a_sb = {2'b0, r[26:24]}; a_sbp = r[27];
      wk_v = r[28] | r[29]; wk_t = {2'b0, s[2:0]};
      alu_b = (s[5:4] == 2'b00); mul_b = (s[7:6] == 2'b00);
      cycle();
    end
    idle(); alu_b = 0; mul_b = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule